// File: doc/BRIEF.md
# PIE Forward-Link Symbol Decoder

This block turns the demodulated reader envelope of a passive tag into data bits. The envelope is a single wire, sampled once per clock. It is high for the body of each symbol and drops low for a short pulse. The decoder measures each symbol as the number of clock edges between two successive low-to-high transitions. It calibrates itself from the preamble that opens every frame, and then classifies each later symbol as a zero or a one.

A frame opens when the line goes low while the decoder is idle. The first transition back to high marks the frame start. The symbol that follows is the reference zero, and it produces no bit. The next symbol is the read calibration; its count is published. The decision threshold is half of that count, rounded down. The third symbol is taken as a transmit calibration only if it is longer than the read calibration; otherwise it is the first data bit. A quiet line with no low-to-high transition for a programmable number of clocks closes the frame.

Top module: `pie_symbol_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every strobe is 0, `trcal_vld_o` is 0, and both calibration counts are 0.
- R2: When the decoder is idle and samples a low level, then samples high, `frame_start_o` pulses for one clock. The pulse comes on the edge after the clock edge that first captures the high level. With one synchroniser stage, that is two edges after the rise is applied.
- R3: A symbol's length equals the number of clock edges from the processing edge of one low-to-high transition to the processing edge of the next one.
- R4: The first symbol after frame start yields no output. The second symbol's length is written to `rtcal_o`, one clock after that symbol ends.
- R5: If the third symbol's length is strictly greater than `rtcal_o`, the decoder writes it to `trcal_o`, sets `trcal_vld_o`, and emits no bit.
- R6: If the third symbol's length is not greater than `rtcal_o`, including the case where the two are equal, it is decoded as a data bit.
- R7: Each data symbol strobes `bit_vld_o` for one clock. `bit_o` is 0 when the length is at most floor(rtcal/2), and 1 when it is above that.
- R8: If no low-to-high transition is processed for TIMEOUT_CNT clocks inside a frame, `frame_end_o` pulses once. No further bits are produced until a new low level and rise open another frame.
- R9: A symbol that ends exactly on the edge where the timeout would fire is decoded normally. The frame stays open.
- R10: `trcal_vld_o` clears at the next frame start. `rtcal_o` and `trcal_o` hold their values until they are overwritten.
- R11: `bit_vld_o`, `frame_start_o` and `frame_end_o` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_i | input | 1 | Envelope: 1 during the symbol body, 0 during the pulse |
| bit_vld_o | output | 1 | One-clock strobe for a decoded data bit |
| bit_o | output | 1 | Decoded bit value, valid with `bit_vld_o` |
| rtcal_o | output | CNT_W | Measured read-calibration length in clocks |
| trcal_o | output | CNT_W | Measured transmit-calibration length in clocks |
| trcal_vld_o | output | 1 | The current frame carried a transmit calibration |
| frame_start_o | output | 1 | One-clock strobe when a frame opens |
| frame_end_o | output | 1 | One-clock strobe when a quiet line closes a frame |

## Verification
Two actions can fall on the same clock edge: the quiet-line timeout and the decoding of a symbol. The bench provokes this with a data symbol exactly TIMEOUT_CNT clocks long, so the closing rise lands on the edge where the counter reaches the limit. The reference model gives the rise priority, and the bench then expects a bit strobe with value 1 and no frame-end pulse at that edge. A second, shorter collision is also exercised: a third symbol equal in length to the read calibration. The bench expects it to be decoded as a bit, not captured as a transmit calibration.

// File: rtl/pie_pkg.sv
package pie_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DELIM,
      ST_REF0,
      ST_RDCAL,
      ST_THIRD,
      ST_DATA
   } pie_state_e;

endpackage

// File: rtl/pie_edge_sampler.sv
module pie_edge_sampler #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic env_i,
   output logic rise_o,
   output logic low_o
);

   localparam int TOP = SYNC_STAGES;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("pie_edge_sampler: SYNC_STAGES must be at least 1");
   end

   // sh_q[TOP-1] is the newest synchronised sample, sh_q[TOP] the one before
   logic [TOP:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '1;
      end else begin
         sh_q <= {sh_q[TOP-1:0], env_i};
      end
   end

   assign rise_o = sh_q[TOP-1] & ~sh_q[TOP];
   assign low_o  = ~sh_q[TOP-1];

endmodule

// File: rtl/pie_interval_counter.sv
module pie_interval_counter #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("pie_interval_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] nxt;

   if (SATURATE) begin : g_sat
      always_comb nxt = (cnt_o == CNT_MAX) ? CNT_MAX : cnt_o + CNT_ONE;

      AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX || cnt_o == CNT_ONE)); // R3
   end else begin : g_wrap
      always_comb nxt = cnt_o + CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else begin
         cnt_o <= restart_i ? CNT_ONE : nxt;
      end
   end

endmodule

// File: rtl/pie_frame_ctrl.sv
module pie_frame_ctrl
   import pie_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int TIMEOUT_CNT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             low_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             bit_vld_o,
   output logic             bit_o,
   output logic [CNT_W-1:0] rtcal_o,
   output logic [CNT_W-1:0] trcal_o,
   output logic             trcal_vld_o,
   output logic             frame_start_o,
   output logic             frame_end_o
);

   localparam logic [CNT_W-1:0] TO_LIM = CNT_W'(TIMEOUT_CNT);

   if (TIMEOUT_CNT < 2 || TIMEOUT_CNT > (2**CNT_W) - 1) begin : g_bad_timeout
      $error("pie_frame_ctrl: TIMEOUT_CNT must lie in 2 .. 2**CNT_W-1");
   end

   pie_state_e       state_q;
   logic [CNT_W-1:0] pivot;
   logic             is_one;
   logic             quiet;

   assign pivot  = rtcal_o >> 1;
   assign is_one = cnt_i > pivot;
   assign quiet  = cnt_i >= TO_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         bit_vld_o     <= 1'b0;
         bit_o         <= 1'b0;
         rtcal_o       <= '0;
         trcal_o       <= '0;
         trcal_vld_o   <= 1'b0;
         frame_start_o <= 1'b0;
         frame_end_o   <= 1'b0;
      end else begin
         bit_vld_o     <= 1'b0;
         frame_start_o <= 1'b0;
         frame_end_o   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (low_i) state_q <= ST_DELIM;
            end
            ST_DELIM: begin
               if (rise_i) begin
                  state_q       <= ST_REF0;
                  frame_start_o <= 1'b1;
                  trcal_vld_o   <= 1'b0;
               end
            end
            default: begin
               if (rise_i) begin
                  unique case (state_q)
                     ST_REF0: state_q <= ST_RDCAL;
                     ST_RDCAL: begin
                        rtcal_o <= cnt_i;
                        state_q <= ST_THIRD;
                     end
                     ST_THIRD: begin
                        state_q <= ST_DATA;
                        if (cnt_i > rtcal_o) begin
                           trcal_o     <= cnt_i;
                           trcal_vld_o <= 1'b1;
                        end else begin
                           bit_vld_o <= 1'b1;
                           bit_o     <= is_one;
                        end
                     end
                     default: begin
                        bit_vld_o <= 1'b1;
                        bit_o     <= is_one;
                     end
                  endcase
               end else if (quiet) begin
                  frame_end_o <= 1'b1;
                  state_q     <= ST_IDLE;
               end
            end
         endcase
      end
   end

   AST_TRCAL_ABOVE_RTCAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trcal_vld_o) |-> (trcal_o > rtcal_o)); // R5

   AST_ZERO_AT_OR_BELOW_PIVOT: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld_o && !bit_o) |-> ({1'b0, $past(cnt_i)} << 1) <= {1'b0, rtcal_o}); // R7

   AST_ONE_ABOVE_PIVOT: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld_o && bit_o) |-> ({1'b0, $past(cnt_i)} << 1) > {1'b0, rtcal_o}); // R7

   AST_END_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_o |-> ($past(cnt_i) >= TO_LIM && !$past(rise_i))); // R8

endmodule

// File: rtl/pie_symbol_decoder.sv
module pie_symbol_decoder #(
   parameter int CNT_W       = 8,
   parameter int TIMEOUT_CNT = 64,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             env_i,
   output logic             bit_vld_o,
   output logic             bit_o,
   output logic [CNT_W-1:0] rtcal_o,
   output logic [CNT_W-1:0] trcal_o,
   output logic             trcal_vld_o,
   output logic             frame_start_o,
   output logic             frame_end_o
);

   logic             rise;
   logic             low;
   logic [CNT_W-1:0] cnt;

   pie_edge_sampler #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .env_i (env_i),
      .rise_o(rise),
      .low_o (low)
   );

   pie_interval_counter #(
      .CNT_W   (CNT_W),
      .SATURATE(1'b1)
   ) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(rise),
      .cnt_o    (cnt)
   );

   pie_frame_ctrl #(
      .CNT_W      (CNT_W),
      .TIMEOUT_CNT(TIMEOUT_CNT)
   ) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise_i       (rise),
      .low_i        (low),
      .cnt_i        (cnt),
      .bit_vld_o    (bit_vld_o),
      .bit_o        (bit_o),
      .rtcal_o      (rtcal_o),
      .trcal_o      (trcal_o),
      .trcal_vld_o  (trcal_vld_o),
      .frame_start_o(frame_start_o),
      .frame_end_o  (frame_end_o)
   );

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bit_vld_o, frame_start_o, frame_end_o})); // R11

endmodule

// File: tb/test_pie_symbol_decoder.sv
module test_pie_symbol_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int TO_CNT     = 64;
   localparam int SYNC       = 1;
   localparam int MAXC       = (1 << CNT_W) - 1;

   localparam int K_BIT = 0;
   localparam int K_FS  = 1;
   localparam int K_FE  = 2;
   localparam int K_RT  = 3;
   localparam int K_TR  = 4;

   localparam int M_IDLE  = 0;
   localparam int M_DELIM = 1;
   localparam int M_REF0  = 2;
   localparam int M_RDCAL = 3;
   localparam int M_THIRD = 4;
   localparam int M_DATA  = 5;

   typedef struct {
      int    cyc;
      int    kind;
      int    val;
      string tag;
   } ev_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             env = 1'b1;
   logic             bit_vld_o, bit_o, trcal_vld_o, frame_start_o, frame_end_o;
   logic [CNT_W-1:0] rtcal_o, trcal_o;

   int  cyc = 0;
   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   ev_t q[$];

   // reference model state
   int   m_st = M_IDLE;
   int   m_last = 0;
   int   m_rt = 0;
   logic m_prev = 1'b1;

   // expected outputs
   int    x_rt = 0, x_tr = 0;
   bit    x_trv = 1'b0, x_bv, x_b, x_fs, x_fe;
   string x_tag;
   ev_t   ev;

   pie_symbol_decoder #(
      .CNT_W(CNT_W), .TIMEOUT_CNT(TO_CNT), .SYNC_STAGES(SYNC)
   ) i_pie_symbol_decoder (
      .clk(clk), .rst_n(rst_n), .env_i(env),
      .bit_vld_o(bit_vld_o), .bit_o(bit_o),
      .rtcal_o(rtcal_o), .trcal_o(trcal_o), .trcal_vld_o(trcal_vld_o),
      .frame_start_o(frame_start_o), .frame_end_o(frame_end_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic push(input int c, input int k, input int v, input string t);
      ev_t n;
      n.cyc = c; n.kind = k; n.val = v; n.tag = t;
      q.push_back(n);
   endtask

   // drive one sample and advance the behavioural model to its processing edge
   task automatic drive(input logic v);
      int  e;
      int  len;
      bit  rise;
      @(negedge clk);
      env  = v;
      e    = cyc + 1 + SYNC;
      rise = v && !m_prev;
      m_prev = v;
      if (m_st == M_IDLE) begin
         if (!v) m_st = M_DELIM;
      end else if (m_st == M_DELIM) begin
         if (rise) begin
            push(e, K_FS, 0, "R2");
            m_last = e;
            m_st   = M_REF0;
         end
      end else begin
         len = e - m_last;
         if (len > MAXC) len = MAXC;
         if (rise) begin
            case (m_st)
               M_REF0:  m_st = M_RDCAL;
               M_RDCAL: begin m_rt = len; push(e, K_RT, len, "R3 R4"); m_st = M_THIRD; end
               M_THIRD: begin
                  if (len > m_rt) push(e, K_TR, len, "R5");
                  else push(e, K_BIT, (2*len > m_rt) ? 1 : 0, "R6");
                  m_st = M_DATA;
               end
               default: push(e, K_BIT, (2*len > m_rt) ? 1 : 0, (len == TO_CNT) ? "R9" : "R7");
            endcase
            m_last = e;
         end else if (len >= TO_CNT) begin
            push(e, K_FE, 0, "R8");
            m_st = M_IDLE;
         end
      end
   endtask

   task automatic hold(input logic v, input int n);
      for (int i = 0; i < n; i++) drive(v);
   endtask

   task automatic sym(input int len, input int pw);
      hold(1'b1, len - pw);
      hold(1'b0, pw);
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         x_bv = 0; x_b = 0; x_fs = 0; x_fe = 0; x_tag = "R7";
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            ev = q.pop_front();
            case (ev.kind)
               K_BIT: begin x_bv = 1; x_b = ev.val[0]; x_tag = ev.tag; end
               K_FS:  begin x_fs = 1; x_trv = 0; end
               K_FE:  x_fe = 1;
               K_RT:  x_rt = ev.val;
               default: begin x_tr = ev.val; x_trv = 1; end
            endcase
         end
         chk(bit_vld_o == x_bv, x_tag, int'(bit_vld_o), int'(x_bv));
         if (x_bv) chk(bit_o == x_b, x_tag, int'(bit_o), int'(x_b));
         chk(frame_start_o == x_fs, "R2", int'(frame_start_o), int'(x_fs));
         chk(frame_end_o == x_fe, "R8", int'(frame_end_o), int'(x_fe));
         chk(int'(rtcal_o) == x_rt, "R4", int'(rtcal_o), x_rt);
         chk(int'(trcal_o) == x_tr, "R5", int'(trcal_o), x_tr);
         chk(trcal_vld_o == x_trv, "R10", int'(trcal_vld_o), int'(x_trv));
         chk($countones({bit_vld_o, frame_start_o, frame_end_o}) <= 1, "R11",
             $countones({bit_vld_o, frame_start_o, frame_end_o}), 1);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(bit_vld_o == 0, "R1", int'(bit_vld_o), 0);
      chk(frame_start_o == 0, "R1", int'(frame_start_o), 0);
      chk(frame_end_o == 0, "R1", int'(frame_end_o), 0);
      chk(rtcal_o == 0, "R1", int'(rtcal_o), 0);
      chk(trcal_o == 0, "R1", int'(trcal_o), 0);
      chk(trcal_vld_o == 0, "R1", int'(trcal_vld_o), 0);
      rst_n = 1'b1;
      hold(1'b1, 5);

      // frame 1: transmit calibration present, pivot 12
      hold(1'b0, 3);
      sym(10, 3);
      sym(25, 3);
      sym(40, 4);
      sym(10, 3);
      sym(12, 3);
      sym(13, 3);
      sym(20, 5);
      hold(1'b1, TO_CNT + 10);

      // frame 2: third symbol equals read calibration, pivot 10
      hold(1'b0, 2);
      sym(8, 2);
      sym(20, 2);
      sym(20, 2);
      sym(10, 2);
      sym(11, 2);
      sym(9, 2);
      hold(1'b1, TO_CNT + 10);

      // frame 3: odd calibration, symbol exactly at the timeout limit
      hold(1'b0, 4);
      sym(6, 1);
      sym(17, 1);
      sym(9, 1);
      sym(8, 1);
      sym(TO_CNT, 3);
      sym(9, 1);
      hold(1'b1, TO_CNT + 10);

      // frame 4: calibration overwritten, line stays quiet afterwards
      hold(1'b0, 1);
      sym(7, 2);
      sym(30, 2);
      sym(31, 2);
      sym(15, 2);
      sym(16, 2);
      hold(1'b1, TO_CNT + 40);

      done = 1'b1;
      chk(q.size() == 0, "R8", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule